// File: doc/BRIEF.md
# Input Capture Unit with Glitch Filter

This block takes a time stamp from a free-running counter when a chosen transition arrives on an asynchronous external capture pin. The pin is first brought into the clock domain by a two-flop synchronizer. An optional filter can be switched in. It passes a new level only when four successive synchronized samples agree, so it removes short glitches at the cost of four extra cycles of latency.

A polarity control selects whether rising or falling transitions count as events. On a qualifying transition the counter value is stored in a capture register and a sticky event flag is set. The flag stays set until software pulses a clear input. When enabled, the flag also drives an interrupt request.

Changing the polarity control or the filter enable never produces an event by itself. A clear that arrives in the same cycle as a new event loses to the event.

Top module: `icap_unit`

## Requirements
- R1: While reset is held, and after it is released, the capture register reads 0 and both the flag and the interrupt request read 0 until an event occurs.
- R2: With `edge_rise_i` = 1 only a low-to-high pin transition is an event. With `edge_rise_i` = 0 only a high-to-low transition is an event. A transition of the other direction leaves the flag and the capture register unchanged.
- R3: With the filter off, suppose the pin changes before clock edge k. Then at edge k+2 the capture register loads the value `count_i` holds at that edge, and the flag rises at that same edge.
- R4: With the filter on, the same event is captured at edge k+6, four cycles later than in R3. The stored value is `count_i` at edge k+6.
- R5: With the filter on, a pin pulse lasting 1, 2 or 3 clock cycles produces no event. A pulse lasting 4 cycles produces an event.
- R6: The flag stays set until `flag_clr_i` is high at a clock edge. After that edge it reads 0, provided no event falls on the same edge.
- R7: When an event and `flag_clr_i` fall on the same clock edge, the flag stays 1 and the capture register takes the new value.
- R8: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.
- R9: An edge in which `edge_rise_i` or `filt_en_i` differs from its value at the previous edge produces no event. Toggling either control while the pin is steady leaves the flag at 0.
- R10: The capture register changes only on an event and holds its value between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous external capture pin |
| count_i | input | W | Free-running counter value to be stamped |
| filt_en_i | input | 1 | 1 selects the four-sample glitch filter |
| edge_rise_i | input | 1 | 1 selects rising events, 0 selects falling events |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear pulse for the event flag |
| cap_value_o | output | W | Last captured counter value |
| cap_flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
An event and a flag clear can fall on the same clock edge. The bench provokes this by computing from the pin-change time which edge carries the capture, then raising `flag_clr_i` for that edge alone. It judges the result by the flag staying at 1 and the capture register holding the arithmetically expected counter value. The pin-change edge also fixes the exact capture edge for both filter settings, so the flag is checked to be still low one cycle before that edge and high right after it.

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  input  logic [W-1:0] count_i,
  input  logic         filt_en_i,
  input  logic         edge_rise_i,
  input  logic         irq_en_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] cap_value_o,
  output logic         cap_flag_o,
  output logic         irq_o
);
  localparam int TAPS = 4;

  logic [1:0]      sync_q;
  logic [TAPS-1:0] sh_q;
  logic            filt_q, prev_q, esel_q, fen_q;
  logic            agree, filt_lvl, level, cfg_chg, trig;

  assign agree    = (&sh_q) | ~(|sh_q);
  assign filt_lvl = agree ? sh_q[0] : filt_q;
  assign level    = filt_en_i ? filt_lvl : sync_q[1];
  assign cfg_chg  = (edge_rise_i != esel_q) | (filt_en_i != fen_q);
  assign trig     = ~cfg_chg & (edge_rise_i ? (level & ~prev_q) : (~level & prev_q));
  assign irq_o    = cap_flag_o & irq_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      sh_q   <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      esel_q <= 1'b0;
      fen_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      sh_q   <= {sh_q[TAPS-2:0], sync_q[1]};
      filt_q <= filt_lvl;
      prev_q <= level;
      esel_q <= edge_rise_i;
      fen_q  <= filt_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value_o <= '0;
      cap_flag_o  <= 1'b0;
    end else if (trig) begin
      cap_value_o <= count_i;
      cap_flag_o  <= 1'b1;
    end else if (flag_clr_i) begin
      cap_flag_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         filt_en_i,
  input logic         edge_rise_i,
  input logic         irq_en_i,
  input logic         flag_clr_i,
  input logic [W-1:0] cap_value_o,
  input logic         cap_flag_o,
  input logic         irq_o,
  input logic         trig
);
  always @(negedge clk)
    if (!rst_n)
      assert_reset_state_R1: assert (cap_value_o == '0 && !cap_flag_o && !irq_o);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_flag_o && !flag_clr_i |=> cap_flag_o);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i && !trig |=> !cap_flag_o);

  assert_capture_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cap_flag_o);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cap_flag_o && irq_en_i);

  assert_no_cfg_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_rise_i != $past(edge_rise_i)) || (filt_en_i != $past(filt_en_i)) |-> !trig);

  assert_value_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(cap_value_o));
endmodule

bind icap_unit icap_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt_en_i(filt_en_i), .edge_rise_i(edge_rise_i),
  .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .cap_value_o(cap_value_o),
  .cap_flag_o(cap_flag_o), .irq_o(irq_o), .trig(trig)
);

// File: tb/icap_unit_bench.sv
module icap_unit_bench;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, pin = 0, fen = 0, rise = 1, ien = 0, clr = 0;
  logic [W-1:0] edge_no = '0;
  logic [W-1:0] cap_value;
  logic cap_flag, irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_no <= edge_no + 1'b1;

  icap_unit #(.W(W)) u_icap_unit (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .count_i(edge_no), .filt_en_i(fen),
    .edge_rise_i(rise), .irq_en_i(ien), .flag_clr_i(clr),
    .cap_value_o(cap_value), .cap_flag_o(cap_flag), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1; waitn(1); clr = 0;
  endtask

  task automatic sweep(input bit f, input bit r);
    int lat;
    logic [W-1:0] e0, held;
    lat = f ? 6 : 2;
    fen = f; rise = r; pin = ~r;
    waitn(12); clear_flag();
    chk(cap_flag == 0, "R6", cap_flag, 0);
    e0 = edge_no; pin = r;
    waitn(lat);
    chk(cap_flag == 0, f ? "R4" : "R3", cap_flag, 0);
    waitn(1);
    chk(cap_flag == 1, r ? "R2" : "R2", cap_flag, 1);
    chk(cap_value == W'(e0 + lat), f ? "R4" : "R3", cap_value, W'(e0 + lat));
    held = cap_value;
    waitn(10); clear_flag();
    pin = ~r; waitn(14);
    chk(cap_flag == 0, "R2", cap_flag, 0);
    chk(cap_value == held, "R10", cap_value, held);
  endtask

  task automatic glitch(input bit f, input int len, input bit expect_evt);
    fen = f; rise = 1; pin = 0;
    waitn(12); clear_flag();
    pin = 1; waitn(len); pin = 0;
    waitn(14);
    chk(cap_flag == expect_evt, "R5", cap_flag, expect_evt);
  endtask

  initial begin
    waitn(3);
    chk(cap_value == 0 && !cap_flag && !irq, "R1", cap_flag, 0);
    rst_n = 1; waitn(4);
    chk(cap_value == 0 && !cap_flag && !irq, "R1", cap_value, 0);

    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 2; r++) sweep(f[0], r[0]);

    for (int len = 1; len <= 4; len++) glitch(1'b1, len, len >= 4);
    glitch(1'b0, 1, 1'b1);

    begin
      logic [W-1:0] e0;
      fen = 0; rise = 1; pin = 0; waitn(10);
      pin = 1; waitn(8); pin = 0; waitn(8);
      chk(cap_flag == 1, "R6", cap_flag, 1);
      waitn(20);
      chk(cap_flag == 1, "R6", cap_flag, 1);
      ien = 0; waitn(1);
      chk(irq == 0, "R8", irq, 0);
      ien = 1; waitn(1);
      chk(irq == 1, "R8", irq, 1);
      e0 = edge_no; pin = 1;
      waitn(2); clr = 1; waitn(1); clr = 0;
      chk(cap_flag == 1, "R7", cap_flag, 1);
      chk(cap_value == W'(e0 + 2), "R7", cap_value, W'(e0 + 2));
      clear_flag();
      chk(cap_flag == 0 && irq == 0, "R6", cap_flag, 0);
    end

    pin = 1; fen = 0; rise = 1; waitn(12); clear_flag();
    for (int i = 0; i < 6; i++) begin
      rise = ~rise; waitn(3);
      fen = ~fen; waitn(3);
    end
    chk(cap_flag == 0, "R9", cap_flag, 0);
    pin = 0; rise = 0; waitn(12); clear_flag();
    for (int i = 0; i < 6; i++) begin
      rise = ~rise; fen = ~fen; waitn(2);
    end
    chk(cap_flag == 0, "R9", cap_flag, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitn(200000);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule